// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns one PWM command into two gate-enable outputs for a half-bridge: a high-side enable that follows the command and a low-side enable that follows its inverse. It guarantees that the two enables are never asserted together. Every dead time is a parameter counted in clock cycles. The defaults assume a 100 MHz clock: 150 ns is 15 cycles, 190 ns is 19 cycles and the low-to-high gap is 3 cycles.

When the high-side switch turns off, the low-side turn-on adapts to the switch node. Two comparator flags report this: one says the node has gone high, the other says it is below a 1 V threshold. If the node was seen high, the low side waits until the node drops below the threshold. If the node never rose, a fixed fallback delay applies. If the node rose but never falls, a longer timeout turns the low side on anyway, which covers negative inductor current. When the low-side switch turns off, the high side waits a fixed internal delay before it turns on.

The PWM input and both flags pass through two-flop synchronizers. An edge on any of them therefore reaches the outputs three clock cycles later. The enable input acts on the next clock edge. After reset or disable, the low side stays off until the first PWM low is seen, which gives the bootstrap capacitor a chance to charge. The analog drive stages and the comparators are outside this block.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While enabled and in steady state, the high-side output is high exactly when the PWM input was high three cycles earlier. The low-side output is high exactly when it was low three cycles earlier. Input changes take effect three cycles later, because of a two-flop synchronizer plus the state register.
- R2: The high-side and low-side outputs are never high in the same cycle.
- R3: On a PWM falling edge the high-side output drops three cycles later, and the low-side output is still low in that cycle.
- R4: On a PWM rising edge the low-side output drops three cycles later. The high-side output rises exactly DT_LH_CYC cycles after that (default 3) and is low in every cycle between.
- R5: With the enable input low at a clock edge, both outputs are low in the cycle after that edge, whatever the PWM input does.
- R6: After reset, or after the enable returns high, both outputs stay low while PWM is high. The low-side output first rises three cycles after PWM is driven low.
- R7: If the switch-node-high flag is seen after high-side turn-off, the low-side output rises three cycles after the below-threshold flag goes true.
- R8: If the switch-node-high flag is never seen after high-side turn-off, the low-side output rises exactly DT_NOHI_CYC cycles (default 15) after the high-side output fell.
- R9: If the switch node was seen high but the below-threshold flag stays false, the low-side output rises exactly DT_MAX_CYC cycles (default 19) after the high-side output fell.
- R10: If PWM rises again during the low-side wait, the low-side output stays off. The high-side output rises DT_LH_CYC cycles after the wait is abandoned.
- R11: If PWM falls again during the high-side wait, the high-side output never rises. The low-side output returns one cycle after the wait is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_in | input | 1 | Enable; low forces both gate enables low |
| pwm_in | input | 1 | PWM command, asynchronous |
| sw_low_in | input | 1 | Switch node is below the 1 V threshold |
| sw_high_in | input | 1 | Switch node has gone high |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The handover is exercised with three switch-node patterns after the PWM fall, each with a different expected low-side turn-on time:
- The node rises, then falls below the threshold. This is the adaptive case, and the turn-on follows the below-threshold flag.
- The node never rises. The turn-on comes at the 15-cycle fallback.
- The node rises and stays up. The turn-on comes at the 19-cycle timeout. A check at cycle 15 shows that this case is not the fallback.

Short PWM pulses that end inside each dead-time wait test both abandon paths. Holding PWM high across reset and across re-enable shows that the low side waits for the first PWM low. Disabling in each conducting state shows that both outputs drop on the next cycle.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LS_ON   = 3'd1,
    ST_HS_WAIT = 3'd2,
    ST_HS_ON   = 3'd3,
    ST_LS_WAIT = 3'd4
  } gate_state_e;

  function automatic int unsigned cnt_bits(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;

  always_comb begin
    meta_d = d_i;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/hbdt_elapsed.sv
module hbdt_elapsed #(
  parameter int unsigned MAX_VAL = 18,
  localparam int unsigned W      = hbdt_pkg::cnt_bits(MAX_VAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] SAT = W'(MAX_VAL);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (cnt_q != SAT);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hbdt_fsm.sv
module hbdt_fsm
  import hbdt_pkg::*;
#(
  parameter int unsigned DT_LH_CYC   = 3,
  parameter int unsigned DT_NOHI_CYC = 15,
  parameter int unsigned DT_MAX_CYC  = 19,
  parameter int unsigned CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          pwm_i,
  input  logic          swlo_i,
  input  logic          swhi_i,
  input  logic [CW-1:0] elapsed_i,
  output logic          clr_o,
  output logic          hs_o,
  output logic          ls_o
);

  localparam logic [CW-1:0] LH_LAST   = CW'(DT_LH_CYC - 1);
  localparam logic [CW-1:0] NOHI_LAST = CW'(DT_NOHI_CYC - 1);
  localparam logic [CW-1:0] MAX_LAST  = CW'(DT_MAX_CYC - 1);

  gate_state_e st_q, st_d;
  logic        seen_q, seen_d;
  logic        hs_q, hs_d;
  logic        ls_q, ls_d;
  logic        hi_now;

  assign hi_now = seen_q | swhi_i;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    if (!pwm_i) st_d = ST_LS_ON;
        ST_LS_ON:   if (pwm_i)  st_d = ST_HS_WAIT;
        ST_HS_WAIT: begin
          if (!pwm_i)                        st_d = ST_LS_ON;
          else if (elapsed_i == LH_LAST)     st_d = ST_HS_ON;
        end
        ST_HS_ON:   if (!pwm_i) st_d = ST_LS_WAIT;
        ST_LS_WAIT: begin
          if (pwm_i)                                    st_d = ST_HS_WAIT;
          else if (hi_now && swlo_i)                    st_d = ST_LS_ON;
          else if (!hi_now && elapsed_i == NOHI_LAST)   st_d = ST_LS_ON;
          else if (hi_now && elapsed_i == MAX_LAST)     st_d = ST_LS_ON;
        end
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    seen_d = (st_q == ST_LS_WAIT) ? hi_now : 1'b0;
    clr_o  = (st_d != st_q);
    hs_d   = (st_d == ST_HS_ON);
    ls_d   = (st_d == ST_LS_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= 1'b0;
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      hs_q   <= hs_d;
      ls_q   <= ls_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int unsigned DT_LH_CYC   = 3,
  parameter int unsigned DT_NOHI_CYC = 15,
  parameter int unsigned DT_MAX_CYC  = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic pwm_in,
  input  logic sw_low_in,
  input  logic sw_high_in,
  output logic hs_gate_o,
  output logic ls_gate_o
);

  localparam int unsigned MAX_A  = (DT_LH_CYC > DT_NOHI_CYC) ? DT_LH_CYC : DT_NOHI_CYC;
  localparam int unsigned MAX_LIM = (MAX_A > DT_MAX_CYC) ? MAX_A : DT_MAX_CYC;
  localparam int unsigned CW      = hbdt_pkg::cnt_bits(MAX_LIM - 1);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          pwm_s;
  logic [1:0]    flag_s;
  logic          clr;
  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  hbdt_sync #(.W(1), .RST_VAL(1'b1)) u_pwm_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (pwm_in),
    .q_o  (pwm_s)
  );

  hbdt_sync #(.W(2), .RST_VAL(2'b00)) u_flag_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  ({sw_high_in, sw_low_in}),
    .q_o  (flag_s)
  );

  hbdt_elapsed #(.MAX_VAL(MAX_LIM - 1)) u_elapsed (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr_i(clr),
    .cnt_o(elapsed)
  );

  hbdt_fsm #(
    .DT_LH_CYC  (DT_LH_CYC),
    .DT_NOHI_CYC(DT_NOHI_CYC),
    .DT_MAX_CYC (DT_MAX_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (en_in),
    .pwm_i    (pwm_s),
    .swlo_i   (flag_s[0]),
    .swhi_i   (flag_s[1]),
    .elapsed_i(elapsed),
    .clr_o    (clr),
    .hs_o     (hs_gate_o),
    .ls_o     (ls_gate_o)
  );

endmodule

// File: rtl/hbdt_chk.sv
module hbdt_chk #(
  parameter int unsigned DT_LH_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic en_in,
  input logic pwm_in,
  input logic hs_gate_o,
  input logic ls_gate_o
);

  localparam int unsigned RW = hbdt_pkg::cnt_bits(DT_LH_CYC);
  localparam logic [RW-1:0] RUN_SAT = RW'(DT_LH_CYC);

  logic [RW-1:0] ls_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ls_low_run <= '0;
    else if (ls_gate_o)          ls_low_run <= '0;
    else if (ls_low_run != RUN_SAT) ls_low_run <= ls_low_run + 1'b1;
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o));

  a_r5_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_in |=> (!hs_gate_o && !ls_gate_o));

  a_r4_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (ls_low_run >= RUN_SAT));

  a_r3_hs_off_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> !$past(hs_gate_o));

  a_r1_hs_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate_o |-> $past(pwm_in, 3));

  a_r1_ls_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate_o |-> !$past(pwm_in, 3));

endmodule

bind hb_deadtime_ctrl hbdt_chk #(.DT_LH_CYC(DT_LH_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_in    (en_in),
  .pwm_in   (pwm_in),
  .hs_gate_o(hs_gate_o),
  .ls_gate_o(ls_gate_o)
);

// File: tb/sim_hb_deadtime_ctrl.sv
module sim_hb_deadtime_ctrl;

  localparam int LH = 3;
  localparam int NOHI = 15;
  localparam int TMAX = 19;
  localparam int LAT = 3;

  logic clk, rst_n, en_in, pwm_in, sw_low_in, sw_high_in;
  logic hs_gate_o, ls_gate_o;

  typedef struct {
    int    due;
    bit    hs;
    bit    ls;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  hb_deadtime_ctrl #(.DT_LH_CYC(LH), .DT_NOHI_CYC(NOHI), .DT_MAX_CYC(TMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .pwm_in(pwm_in),
    .sw_low_in(sw_low_in), .sw_high_in(sw_high_in),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int due, input bit hs, input bit ls, input string req);
    exp_t e;
    e.due = due; e.hs = hs; e.ls = ls; e.req = req;
    q.push_back(e);
  endtask

  // monitor: overlap every cycle (R2) plus scheduled scoreboard items
  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (hs_gate_o && ls_gate_o) begin
        mismatched++;
        $display("FAIL R2 cyc=%0d actual hs=%b ls=%b expected not both high", cyc, hs_gate_o, ls_gate_o);
      end
    end
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (e.due != cyc || hs_gate_o !== e.hs || ls_gate_o !== e.ls) begin
        mismatched++;
        $display("FAIL %s cyc=%0d due=%0d actual hs=%b ls=%b expected hs=%b ls=%b",
                 e.req, cyc, e.due, hs_gate_o, ls_gate_o, e.hs, e.ls);
      end
    end
  end

  task automatic go_high();
    pwm_in = 1'b1;
    tick(10);
  endtask

  task automatic go_low_settle();
    pwm_in = 1'b0;
    tick(NOHI + 6);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; en_in = 1'b1; pwm_in = 1'b1; sw_low_in = 1'b1; sw_high_in = 1'b0;
    tick(3);
    compared++;
    if (hs_gate_o !== 1'b0 || ls_gate_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R6 reset actual hs=%b ls=%b expected hs=0 ls=0", hs_gate_o, ls_gate_o);
    end
    rst_n = 1'b1;
    n = cyc;
    // R6: PWM held high after reset keeps both outputs low
    push(n + 2, 0, 0, "R6"); push(n + 8, 0, 0, "R6");
    tick(10);

    // R6: first PWM low turns the low side on
    n = cyc; pwm_in = 1'b0;
    push(n + 2, 0, 0, "R6"); push(n + LAT, 0, 1, "R6");
    tick(6);

    // R4 / R1: low-to-high with fixed gap
    n = cyc; pwm_in = 1'b1;
    push(n + LAT, 0, 0, "R4"); push(n + LAT + LH - 1, 0, 0, "R4");
    push(n + LAT + LH, 1, 0, "R1");
    tick(10);

    // R3 / R7: adaptive handover, node seen high then falls below 1 V
    n = cyc; pwm_in = 1'b0; sw_high_in = 1'b1; sw_low_in = 1'b0;
    push(n + LAT, 0, 0, "R3");
    tick(5);
    sw_high_in = 1'b0; sw_low_in = 1'b1;
    push(n + 7, 0, 0, "R7"); push(n + 5 + LAT, 0, 1, "R7");
    tick(8);
    go_high();

    // R8: node never rises, fixed fallback
    n = cyc; pwm_in = 1'b0;
    push(n + LAT, 0, 0, "R8"); push(n + LAT + NOHI - 1, 0, 0, "R8");
    push(n + LAT + NOHI, 0, 1, "R8");
    tick(NOHI + 6);
    go_high();

    // R9: node high and never falls, timeout
    n = cyc; pwm_in = 1'b0; sw_high_in = 1'b1; sw_low_in = 1'b0;
    push(n + LAT + NOHI, 0, 0, "R9"); push(n + LAT + TMAX - 1, 0, 0, "R9");
    push(n + LAT + TMAX, 0, 1, "R9");
    tick(TMAX + 6);
    sw_high_in = 1'b0; sw_low_in = 1'b1;
    go_high();

    // R10: PWM rises again during the low-side wait
    n = cyc; pwm_in = 1'b0;
    tick(6);
    pwm_in = 1'b1;
    push(n + 6 + LAT, 0, 0, "R10"); push(n + 6 + LAT + LH - 1, 0, 0, "R10");
    push(n + 6 + LAT + LH, 1, 0, "R10"); push(n + NOHI + 4, 1, 0, "R10");
    tick(NOHI + 8);

    // R11: PWM falls again during the high-side wait
    go_low_settle();
    n = cyc; pwm_in = 1'b1;
    tick(1);
    pwm_in = 1'b0;
    push(n + LAT, 0, 0, "R11"); push(n + LAT + 1, 0, 1, "R11");
    push(n + LAT + 2, 0, 1, "R11"); push(n + LAT + 4, 0, 1, "R11");
    tick(10);

    // R5: disable while high side on, PWM toggling while disabled
    go_high();
    n = cyc; en_in = 1'b0;
    push(n + 1, 0, 0, "R5");
    tick(2);
    pwm_in = 1'b0;
    push(n + 2 + LAT + 1, 0, 0, "R5");
    tick(6);
    pwm_in = 1'b1;
    tick(4);
    // R6: re-enable with PWM high keeps both low until PWM low
    n = cyc; en_in = 1'b1;
    push(n + 6, 0, 0, "R6");
    tick(8);
    n = cyc; pwm_in = 1'b0;
    push(n + LAT, 0, 1, "R6");
    tick(5);
    // R5: disable while low side on
    n = cyc; en_in = 1'b0;
    push(n + 1, 0, 0, "R5"); push(n + 4, 0, 0, "R5");
    tick(6);

    wait (q.size() == 0);
    tick(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule